// File: doc/BRIEF.md
# Mask-Bit Prefix-Count Unit

This block turns a per-lane boolean vector into a vector of 32-bit running counts of set bits in a single operation. Software uses it to derive ragged-row offsets: each output lane holds the number of active lanes at or below its own position. The boolean vector is never supplied directly. It sits in a small 16-entry mask file that a plain write port fills, and each request names an entry of that file by index.

Requests arrive on a valid/ready stream together with a reduction code, a flag that says whether a separate lane mask was supplied, and a whole-op predicate. The operation only sums. A request that asks for another reduction, that brings its own lane mask, or that names an entry outside the 16-entry band returns an error beat with all counts zero instead of a result. A request whose predicate is false is consumed but produces no beat. Results leave on a registered valid/ready stream one cycle after acceptance. The result register is the only buffer. While a beat waits on a low `res_ready`, the block holds the beat unchanged and deasserts `req_ready`. When the waiting beat is taken in a cycle, a new request can be accepted in that same cycle.

Top module: `bitcount_prefix_unit`

## Requirements
- R1: After reset `res_valid` is 0 and every mask-file entry holds all zeros, so a sum request to any entry in the band returns counts of 0 in every lane.
- R2: For a valid request, output lane i (bits 32*i+31 down to 32*i of `res_counts`) equals the number of set bits among bits 0..i of the addressed mask entry, zero-extended to 32 bits. Bit i of the entry belongs to lane i, and there are 8 lanes.
- R3: A request accepted with `req_pred`=1 appears on the output with `res_valid`=1 at the clock edge that accepts it, which is one cycle of latency.
- R4: The reduction code `req_red` is 2 bits, and 0 means sum. Any other value yields a beat with `res_err`=1 and all counts 0.
- R5: A request with `req_has_lmask`=1 yields a beat with `res_err`=1 and all counts 0.
- R6: A mask index `req_midx` of 16 or above yields a beat with `res_err`=1 and all counts 0. Indices 0..15 are valid.
- R7: A request accepted with `req_pred`=0 produces no output beat (`res_valid`=0 at the next cycle), even when it would be an error.
- R8: While `res_valid`=1 and `res_ready`=0, `req_ready` is 0 and `res_counts` and `res_err` hold their values. A request offered during such a stall is not taken.
- R9: A write through `mf_we`/`mf_waddr`/`mf_wdata` is seen by requests accepted at later edges. A request accepted at the same edge as a write to its entry sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_we | input | 1 | Mask-file write enable |
| mf_waddr | input | 4 | Mask-file write entry |
| mf_wdata | input | 8 | Boolean lane vector to store, bit i is lane i |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_midx | input | 5 | Source mask entry index |
| req_red | input | 2 | Reduction code, 0 is sum |
| req_has_lmask | input | 1 | A separate lane mask was supplied |
| req_pred | input | 1 | Whole-op predicate |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer takes the beat |
| res_counts | output | 256 | Eight 32-bit inclusive counts, lane 0 in the low bits |
| res_err | output | 1 | Beat reports a rejected request |

## Verification
The assertions check the stream rules on every cycle: a stalled beat and its payload stay stable, `req_ready` falls during a stall, a predicated request produces a beat one cycle later, and an unpredicated one produces none. They also check that every error beat carries zero counts, that a lane-mask or out-of-band request is flagged, and that the counts never drop or step by more than one from lane to lane. Only the bench can show that the counts match the exact bits stored in the addressed entry. The same holds for the old-value rule of a write and a read at one edge, the zeroed file after reset, and the reduction-code check.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  localparam int LANES   = 8;
  localparam int CNT_W   = 32;
  localparam int MREGS   = 16;
  localparam int IDX_W   = 5;
  localparam int RED_W   = 2;
  localparam int RED_SUM = 0;
endpackage

// File: rtl/bcp_mask_file.sv
module bcp_mask_file #(
  parameter int LANES = 8,
  parameter int MREGS = 16,
  localparam int AW = $clog2(MREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [LANES-1:0] rdata
);
  logic [LANES-1:0] entry_q [MREGS];

  for (genvar e = 0; e < MREGS; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         entry_q[e] <= '0;
      else if (we && waddr == AW'(e))     entry_q[e] <= wdata;
    end
  end

  assign rdata = entry_q[raddr];
endmodule

// File: rtl/bcp_req_check.sv
module bcp_req_check #(
  parameter int MREGS   = 16,
  parameter int IDX_W   = 5,
  parameter int RED_W   = 2,
  parameter int RED_SUM = 0,
  localparam int AW = $clog2(MREGS)
) (
  input  logic [IDX_W-1:0] midx,
  input  logic [RED_W-1:0] red,
  input  logic             has_lmask,
  output logic             err,
  output logic [AW-1:0]    raddr
);
  logic out_of_band, bad_red;

  always_comb begin
    out_of_band = (midx >= IDX_W'(MREGS));
    bad_red     = (red != RED_W'(RED_SUM));
    err         = out_of_band | bad_red | has_lmask;
    raddr       = midx[AW-1:0];
  end
endmodule

// File: rtl/bcp_prefix_count.sv
module bcp_prefix_count #(
  parameter int LANES = 8,
  parameter int CNT_W = 32,
  localparam int SW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]       bits,
  output logic [LANES*CNT_W-1:0] counts
);
  logic [SW-1:0] run [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign run[i] = SW'(bits[0]);
    end else begin : g_next
      assign run[i] = run[i-1] + SW'(bits[i]);
    end
    assign counts[i*CNT_W +: CNT_W] = CNT_W'(run[i]);
  end
endmodule

// File: rtl/bitcount_prefix_unit.sv
module bitcount_prefix_unit
  import bcp_pkg::*;
#(
  parameter int LANES_P = LANES,
  parameter int CNT_W_P = CNT_W,
  parameter int MREGS_P = MREGS,
  parameter int IDX_W_P = IDX_W,
  localparam int AW = $clog2(MREGS_P)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mf_we,
  input  logic [AW-1:0]            mf_waddr,
  input  logic [LANES_P-1:0]       mf_wdata,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [IDX_W_P-1:0]       req_midx,
  input  logic [RED_W-1:0]         req_red,
  input  logic                     req_has_lmask,
  input  logic                     req_pred,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [LANES_P*CNT_W_P-1:0] res_counts,
  output logic                     res_err
);
  logic                         chk_err;
  logic [AW-1:0]                rd_addr;
  logic [LANES_P-1:0]           rd_bits;
  logic [LANES_P*CNT_W_P-1:0]   pfx;
  logic                         accept;

  bcp_req_check #(.MREGS(MREGS_P), .IDX_W(IDX_W_P), .RED_W(RED_W), .RED_SUM(RED_SUM)) u_check (
    .midx(req_midx), .red(req_red), .has_lmask(req_has_lmask),
    .err(chk_err), .raddr(rd_addr)
  );

  bcp_mask_file #(.LANES(LANES_P), .MREGS(MREGS_P)) u_file (
    .clk(clk), .rst_n(rst_n), .we(mf_we), .waddr(mf_waddr), .wdata(mf_wdata),
    .raddr(rd_addr), .rdata(rd_bits)
  );

  bcp_prefix_count #(.LANES(LANES_P), .CNT_W(CNT_W_P)) u_pfx (
    .bits(rd_bits), .counts(pfx)
  );

  // Output register is the only buffer: take a new request when it is empty or draining
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_counts <= '0;
      res_err    <= 1'b0;
    end else if (accept) begin
      res_valid <= req_pred;
      if (req_pred) begin
        res_err    <= chk_err;
        res_counts <= chk_err ? '0 : pfx;
      end
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bcp_checker.sv
module bcp_checker #(
  parameter int LANES = 8,
  parameter int CNT_W = 32,
  parameter int MREGS = 16,
  parameter int IDX_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [IDX_W-1:0]       req_midx,
  input logic                   req_has_lmask,
  input logic                   req_pred,
  input logic                   res_valid,
  input logic                   res_ready,
  input logic [LANES*CNT_W-1:0] res_counts,
  input logic                   res_err
);
  logic take;
  logic steps_ok;
  assign take = req_valid && req_ready;

  always_comb begin
    logic [CNT_W-1:0] prev, cur;
    steps_ok = 1'b1;
    prev = '0;
    for (int i = 0; i < LANES; i++) begin
      cur = res_counts[i*CNT_W +: CNT_W];
      if (cur < prev || cur > prev + 1) steps_ok = 1'b0;
      prev = cur;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_counts) && $stable(res_err));
  assert_stall_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready);
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_pred |=> res_valid);
  assert_no_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && !req_pred |=> !res_valid);
  assert_lmask_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_pred && req_has_lmask |=> res_err);
  assert_band_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_pred && (req_midx >= IDX_W'(MREGS)) |=> res_err);
  assert_err_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_err |-> res_counts == '0);
  assert_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_err |-> steps_ok);
endmodule

bind bitcount_prefix_unit bcp_checker #(
  .LANES(LANES_P), .CNT_W(CNT_W_P), .MREGS(MREGS_P), .IDX_W(IDX_W_P)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_midx(req_midx), .req_has_lmask(req_has_lmask), .req_pred(req_pred),
  .res_valid(res_valid), .res_ready(res_ready), .res_counts(res_counts), .res_err(res_err)
);

// File: tb/sim_bitcount_prefix_unit.sv
`timescale 1ns/1ps
module sim_bitcount_prefix_unit;
  logic clk = 0, rst_n = 0;
  logic mf_we = 0; logic [3:0] mf_waddr = 0; logic [7:0] mf_wdata = 0;
  logic req_valid = 0, req_ready; logic [4:0] req_midx = 0; logic [1:0] req_red = 0;
  logic req_has_lmask = 0, req_pred = 1;
  logic res_valid, res_ready = 1; logic [255:0] res_counts; logic res_err;
  int errors = 0, checks = 0;
  logic [7:0] shadow [16];

  always #4 clk = ~clk;

  bitcount_prefix_unit u0 (.*);

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [255:0] exp_counts(input logic [7:0] m);
    logic [255:0] v = '0; int c = 0;
    for (int i = 0; i < 8; i++) begin c += m[i]; v[i*32 +: 32] = 32'(c); end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); mf_we = 1; mf_waddr = a; mf_wdata = d;
    @(negedge clk); mf_we = 0; shadow[a] = d;
  endtask

  // Issue one request at a negedge, accept at posedge, sample at the following negedge
  task automatic req(input logic [4:0] idx, input logic [1:0] red, input logic lm, input logic pr);
    @(negedge clk); req_valid = 1; req_midx = idx; req_red = red; req_has_lmask = lm; req_pred = pr;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic expect_beat(input string tag, input logic [4:0] idx, input logic [1:0] red,
                             input logic lm, input logic pr);
    logic bad = (idx >= 16) || (red != 0) || lm;
    chk({tag, " valid"}, 256'(res_valid), 256'(pr));
    if (pr) begin
      chk({tag, " err"}, 256'(res_err), 256'(bad));
      chk({tag, " counts"}, res_counts, bad ? '0 : exp_counts(shadow[idx[3:0]]));
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", 256'(res_valid), 256'(0));
    rst_n = 1;
    req(5'd9, 2'd0, 0, 1);
    expect_beat("R1 zeroed entry", 5'd9, 0, 0, 1);

    // R2 directed patterns
    wr(4'd0, 8'hFF); req(5'd0, 0, 0, 1); expect_beat("R2 all ones", 5'd0, 0, 0, 1);
    wr(4'd1, 8'h80); req(5'd1, 0, 0, 1); expect_beat("R2 top lane only", 5'd1, 0, 0, 1);
    wr(4'd15, 8'h55); req(5'd15, 0, 0, 1); expect_beat("R2 alternating top entry", 5'd15, 0, 0, 1);
    // R3 latency: beat present right after accepting edge, gone a cycle later
    req(5'd0, 0, 0, 1);
    chk("R3 beat one cycle later", 256'(res_valid), 256'(1));
    @(negedge clk);
    chk("R3 beat drained", 256'(res_valid), 256'(0));
    // R4 bad reductions
    for (int r = 1; r < 4; r++) begin
      req(5'd0, 2'(r), 0, 1); expect_beat("R4 non-sum code", 5'd0, 2'(r), 0, 1);
    end
    // R5 lane mask supplied
    req(5'd0, 0, 1, 1); expect_beat("R5 lane mask supplied", 5'd0, 0, 1, 1);
    // R6 out of band
    req(5'd16, 0, 0, 1); expect_beat("R6 index 16", 5'd16, 0, 0, 1);
    req(5'd31, 0, 0, 1); expect_beat("R6 index 31", 5'd31, 0, 0, 1);
    // R7 predicate false, even for an error request
    req(5'd0, 0, 0, 0); chk("R7 no beat", 256'(res_valid), 256'(0));
    req(5'd20, 2'd1, 1, 0); chk("R7 no beat on error", 256'(res_valid), 256'(0));
    // R9 same-edge write and read sees old value
    wr(4'd3, 8'h0F);
    @(negedge clk); mf_we = 1; mf_waddr = 4'd3; mf_wdata = 8'hF0;
    req_valid = 1; req_midx = 5'd3; req_red = 0; req_has_lmask = 0; req_pred = 1;
    @(negedge clk); mf_we = 0; req_valid = 0;
    chk("R9 same edge old value", res_counts, exp_counts(8'h0F));
    shadow[3] = 8'hF0;
    req(5'd3, 0, 0, 1); expect_beat("R9 later sees new", 5'd3, 0, 0, 1);
    // R8 back-pressure
    wr(4'd4, 8'h3C);
    @(negedge clk); res_ready = 0; req_valid = 1; req_midx = 5'd4; req_red = 0; req_has_lmask = 0; req_pred = 1;
    @(negedge clk); req_midx = 5'd0;
    for (int k = 0; k < 3; k++) begin
      chk("R8 ready low in stall", 256'(req_ready), 256'(0));
      chk("R8 beat held", res_counts, exp_counts(8'h3C));
      @(negedge clk);
    end
    req_valid = 0; res_ready = 1;
    chk("R8 held beat still valid", 256'(res_valid), 256'(1));
    @(negedge clk);
    chk("R8 stalled offer not taken", 256'(res_valid), 256'(0));

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 3) wr(4'($urandom_range(0, 15)), 8'($urandom));
      else begin
        logic [4:0] idx = (sel == 9) ? 5'($urandom) : 5'($urandom_range(0, 15));
        logic [1:0] rd = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'd0;
        logic lm = ($urandom_range(0, 7) == 0);
        logic pr = ($urandom_range(0, 5) != 0);
        req(idx, rd, lm, pr);
        expect_beat("R2 random request", idx, rd, lm, pr);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule